// File: doc/BRIEF.md
# Half-Warp Memory Access Coalescer

The block takes one memory instruction issued by a group of sixteen threads with contiguous thread indices. It receives a byte address and an active flag for each thread and a code for the word size. It turns these into the smallest set of aligned memory transactions it can build. Transactions leave one per cycle over a valid/ready handshake. Each transaction carries an aligned base address, a length in bytes and a mask of the threads it serves.

A mode input selects one of two grouping policies:
- **Strict:** merges accesses only when every active thread sits at its own word slot of one aligned block.
- **Relaxed:** merges any accesses that share an aligned segment. It then narrows each transaction to the smallest aligned piece that still covers the threads it serves.

Only address and transaction generation is modelled. No data moves through the block.

Top module: `hw_coalescer`

## Requirements
- R1: `in_ready` is high exactly when no thread of the current instruction is still waiting for a transaction, and an instruction is taken only on a cycle with `in_valid` and `in_ready` both high. If an instruction has no active thread, or has only misaligned ones, it yields no transaction and leaves `in_ready` high.
- R2: `in_size` codes 0, 1, 2, 3 and 4 mean words of 1, 2, 4, 8 and 16 bytes. An active thread whose address is not a multiple of its word size gets a set bit at its index in `err_mask` from the cycle after acceptance until the next acceptance, and it is served by no transaction.
- R3: In strict mode with words of 1 to 8 bytes, suppose every served thread k lies at base + k*w and base is aligned to 16*w bytes. Then a single transaction of 16*w bytes at base serves them all, and inactive threads do not prevent this.
- R4: In strict mode with 16-byte words, in-order threads at a 128-byte aligned base give one 128-byte transaction at base for threads 0 to 7 and one at base+128 for threads 8 to 15. Each transaction is issued only if some thread in that half is active.
- R5: In strict mode, if any served thread is out of order or the base is misaligned, each served thread gets its own 32-byte transaction at its address rounded down to 32 bytes, with a one-hot mask, in ascending thread order.
- R6: In relaxed mode the nominal segment is 32 bytes for 1-byte words, 64 bytes for 2-byte words and 128 bytes for wider words. Each transaction is built around the lowest-numbered waiting thread and serves every waiting thread in the same aligned segment.
- R7: In relaxed mode a segment whose served addresses all lie in one half is reduced to that half, repeatedly, but never below 32 bytes.
- R8: The masks of one instruction's transactions are disjoint, their union equals the active threads minus the misaligned ones, and every `out_addr` is a multiple of its `out_len`.
- R9: While `out_valid` is high and `out_ready` is low, the offered transaction is held unchanged.
- R10: `in_relaxed` = 1 selects relaxed grouping and 0 selects strict grouping, captured with the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | No thread waiting; instruction can be taken |
| in_relaxed | input | 1 | 1 = relaxed grouping, 0 = strict grouping |
| in_size | input | 3 | Word size code, 0..4 for 1..16 bytes |
| in_addr | input | 512 | Per-thread byte addresses, thread k at bits 32k+31:32k |
| in_active | input | 16 | Per-thread active flags |
| err_mask | output | 16 | Misaligned active threads of the last instruction |
| out_valid | output | 1 | Transaction offered |
| out_ready | input | 1 | Transaction taken by the memory side |
| out_addr | output | 32 | Aligned transaction base address |
| out_len | output | 8 | Transaction length in bytes |
| out_mask | output | 16 | Threads served by the transaction |

## Verification
The bench goes after these corner cases:

- **Base aligned to 32 but not 64 bytes (32-bit words, strict mode).** A design that tested only word ordering would wrongly return one transaction instead of sixteen.
- **Pairwise swapped threads.** This pattern must split in strict mode but fold into a single 64-byte transaction in relaxed mode. A design that mixed up the policies would show it at once.
- **Run that straddles a 128-byte line.** It must produce one 64-byte and one 32-byte transaction. A design that failed to shrink transactions would send two 128-byte ones instead.
- **Sparse masks, one misaligned thread, 16-byte words and an all-inactive instruction.** These catch a design that lets gaps break strict grouping, leaks an erroring thread into a transaction mask, emits a third line for 16-byte words, or stalls on an empty instruction.

// File: rtl/hw_coalescer.sv
module hw_coalescer #(
  parameter int THREADS    = 16,
  parameter int AW         = 32,
  parameter int LW         = 8,
  parameter int SEG_MIN_LG = 5,
  parameter int SEG_MAX_LG = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_relaxed,
  input  logic [2:0]            in_size,
  input  logic [THREADS*AW-1:0] in_addr,
  input  logic [THREADS-1:0]    in_active,
  output logic [THREADS-1:0]    err_mask,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [AW-1:0]         out_addr,
  output logic [LW-1:0]         out_len,
  output logic [THREADS-1:0]    out_mask
);
  localparam int TLG = $clog2(THREADS);
  localparam int IW  = (TLG > 0) ? TLG : 1;
  localparam int HALVINGS = SEG_MAX_LG - SEG_MIN_LG;

  logic [AW-1:0]      a_in [THREADS];
  logic [AW-1:0]      a_q  [THREADS];
  logic [THREADS-1:0] pend_q, err_q, good_d, bad_d, m;
  logic [2:0]         size_q;
  logic               rel_q, split_q, split_d;
  logic               accept, fire;

  assign in_ready  = ~|pend_q;
  assign out_valid = |pend_q;
  assign err_mask  = err_q;
  assign accept    = in_valid & in_ready;
  assign fire      = out_valid & out_ready;

  always_comb begin : classify
    logic [AW-1:0] wm, base;
    logic [IW-1:0] lead;
    logic          ordered;
    int            clg;
    wm      = (AW'(1) << in_size) - AW'(1);
    lead    = '0;
    good_d  = '0;
    bad_d   = '0;
    for (int k = THREADS - 1; k >= 0; k--) begin
      a_in[k] = in_addr[k*AW +: AW];
      if (in_active[k]) begin
        if ((a_in[k] & wm) != '0) bad_d[k] = 1'b1;
        else begin
          good_d[k] = 1'b1;
          lead      = IW'(k);
        end
      end
    end
    base    = a_in[lead] - (AW'(lead) << in_size);
    ordered = 1'b1;
    for (int k = 0; k < THREADS; k++)
      if (good_d[k] && a_in[k] != base + (AW'(k) << in_size)) ordered = 1'b0;
    clg = int'(in_size) + TLG;
    if (clg > SEG_MAX_LG) clg = SEG_MAX_LG;
    if ((base & ((AW'(1) << clg) - AW'(1))) != '0) ordered = 1'b0;
    split_d = ~ordered;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      err_q   <= '0;
      size_q  <= '0;
      rel_q   <= 1'b0;
      split_q <= 1'b0;
      for (int k = 0; k < THREADS; k++) a_q[k] <= '0;
    end else if (accept) begin
      pend_q  <= good_d;
      err_q   <= bad_d;
      size_q  <= in_size;
      rel_q   <= in_relaxed;
      split_q <= split_d;
      for (int k = 0; k < THREADS; k++) a_q[k] <= a_in[k];
    end else if (fire) begin
      pend_q <= pend_q & ~out_mask;
    end
  end

  always_comb begin : emit
    logic [IW-1:0] ld;
    logic [AW-1:0] la;
    logic          any0, any1;
    int            slg;
    ld = '0;
    for (int k = THREADS - 1; k >= 0; k--)
      if (pend_q[k]) ld = IW'(k);
    la = a_q[ld];
    if (rel_q) slg = SEG_MIN_LG + int'(size_q);
    else if (split_q) slg = SEG_MIN_LG;
    else slg = int'(size_q) + TLG;
    if (slg > SEG_MAX_LG) slg = SEG_MAX_LG;
    for (int k = 0; k < THREADS; k++) begin
      if (!rel_q && split_q) m[k] = pend_q[k] && (IW'(k) == ld);
      else m[k] = pend_q[k] && ((a_q[k] >> slg) == (la >> slg));
    end
    for (int s = 0; s < HALVINGS; s++) begin
      any0 = 1'b0;
      any1 = 1'b0;
      if (rel_q && slg > SEG_MIN_LG) begin
        for (int k = 0; k < THREADS; k++)
          if (m[k]) begin
            if (((a_q[k] >> (slg - 1)) & AW'(1)) != '0) any1 = 1'b1;
            else any0 = 1'b1;
          end
        if (!(any0 && any1)) slg = slg - 1;
      end
    end
    out_addr = (la >> slg) << slg;
    out_len  = LW'(1) << slg;
    out_mask = m;
  end
endmodule

// File: rtl/hw_coalescer_chk.sv
module hw_coalescer_chk #(
  parameter int THREADS = 16,
  parameter int AW      = 32,
  parameter int LW      = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_relaxed,
  input logic [THREADS-1:0] in_active,
  input logic [THREADS-1:0] err_mask,
  input logic               out_valid,
  input logic               out_ready,
  input logic [AW-1:0]      out_addr,
  input logic [LW-1:0]      out_len,
  input logic [THREADS-1:0] out_mask
);
  logic [THREADS-1:0] served, act_q;
  logic               rel_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      served <= '0;
      act_q  <= '0;
      rel_c  <= 1'b0;
    end else if (in_valid && in_ready) begin
      served <= '0;
      act_q  <= in_active;
      rel_c  <= in_relaxed;
    end else if (out_valid && out_ready) begin
      served <= served | out_mask;
    end
  end

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);
  p_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_active == '0) |=> in_ready);
  p_err_unserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask & err_mask) == '0);
  p_min_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && rel_c) |-> out_len >= LW'(32));
  p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_len) == 1 && (out_addr & (AW'(out_len) - AW'(1))) == '0));
  p_disjoint_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask & served) == '0);
  p_union_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> served == (act_q & ~err_mask));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_mask) && $stable(out_len)));
endmodule

bind hw_coalescer hw_coalescer_chk #(.THREADS(THREADS), .AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_relaxed(in_relaxed), .in_active(in_active), .err_mask(err_mask),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
  .out_len(out_len), .out_mask(out_mask));

// File: tb/hw_coalescer_test.sv
module hw_coalescer_test;
  localparam int T = 16;
  localparam int NV = 21;

  typedef struct packed {
    logic        rel;
    logic [2:0]  sz;
    logic [1:0]  pat;
    logic [31:0] base;
    logic [15:0] act;
    logic [4:0]  cnt;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd2, 2'd0, 32'h1000, 16'hFFFF, 5'd1},
    '{1'b0, 3'd2, 2'd1, 32'h1000, 16'hFFFF, 5'd16},
    '{1'b0, 3'd2, 2'd0, 32'h1020, 16'hFFFF, 5'd16},
    '{1'b0, 3'd2, 2'd0, 32'h1000, 16'h5A5A, 5'd1},
    '{1'b0, 3'd4, 2'd0, 32'h2000, 16'hFFFF, 5'd2},
    '{1'b0, 3'd4, 2'd0, 32'h2080, 16'hFFFF, 5'd2},
    '{1'b0, 3'd0, 2'd0, 32'h3000, 16'hFFFF, 5'd1},
    '{1'b0, 3'd3, 2'd0, 32'h3000, 16'hFFFF, 5'd1},
    '{1'b0, 3'd2, 2'd3, 32'h1000, 16'hFFFF, 5'd1},
    '{1'b0, 3'd2, 2'd1, 32'h1000, 16'h8001, 5'd2},
    '{1'b0, 3'd2, 2'd2, 32'h5000, 16'h00FF, 5'd8},
    '{1'b0, 3'd2, 2'd0, 32'h1000, 16'h0000, 5'd0},
    '{1'b1, 3'd2, 2'd1, 32'h1000, 16'hFFFF, 5'd1},
    '{1'b1, 3'd2, 2'd0, 32'h1050, 16'hFFFF, 5'd2},
    '{1'b1, 3'd0, 2'd0, 32'h4000, 16'hFFFF, 5'd1},
    '{1'b1, 3'd2, 2'd2, 32'h5000, 16'hFFFF, 5'd4},
    '{1'b1, 3'd3, 2'd0, 32'h6000, 16'h000F, 5'd1},
    '{1'b1, 3'd4, 2'd0, 32'h7000, 16'hFFFF, 5'd2},
    '{1'b1, 3'd1, 2'd0, 32'h1010, 16'hFFFF, 5'd1},
    '{1'b1, 3'd2, 2'd3, 32'h1000, 16'hFFFF, 5'd1},
    '{1'b1, 3'd2, 2'd2, 32'h5000, 16'h1111, 5'd4}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_relaxed = 1'b0;
  logic [2:0]    in_size = '0;
  logic [T*32-1:0] in_addr = '0;
  logic [T-1:0]  in_active = '0;
  logic          out_ready = 1'b0;
  logic          in_ready, out_valid;
  logic [T-1:0]  err_mask, out_mask;
  logic [31:0]   out_addr;
  logic [7:0]    out_len;

  int checks = 0;
  int errors = 0;
  logic [31:0] cur [T];
  logic [31:0] ex_addr [T];
  logic [7:0]  ex_len [T];
  logic [15:0] ex_mask [T];
  logic [15:0] ex_err;
  int ex_n;

  always #5 clk = ~clk;

  hw_coalescer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_relaxed(in_relaxed), .in_size(in_size), .in_addr(in_addr),
    .in_active(in_active), .err_mask(err_mask), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_len(out_len),
    .out_mask(out_mask));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(vec_t v);
    if (v.rel) return "R6 R7 R10";
    if (v.sz == 3'd4) return "R4";
    if (v.pat == 2'd0) return "R3";
    return "R3 R5";
  endfunction

  task automatic mk_addr(input vec_t v);
    logic [31:0] w;
    w = 32'd1 << v.sz;
    for (int k = 0; k < T; k++) begin
      case (v.pat)
        2'd0: cur[k] = v.base + k * w;
        2'd1: cur[k] = v.base + (k ^ 1) * w;
        2'd2: cur[k] = v.base + k * 32;
        default: cur[k] = v.base + k * w + ((k == 5) ? 1 : 0);
      endcase
    end
  endtask

  task automatic push(input logic [31:0] a, input int len, input logic [15:0] m);
    ex_addr[ex_n] = a;
    ex_len[ex_n]  = 8'(len);
    ex_mask[ex_n] = m;
    ex_n++;
  endtask

  task automatic model(input vec_t v);
    logic [15:0] pend, m;
    logic [31:0] w, base, seg;
    int lead, len, span, h;
    bit ok, lo, hi;
    w = 32'd1 << v.sz;
    pend = '0; ex_err = '0; ex_n = 0;
    for (int k = 0; k < T; k++)
      if (v.act[k]) begin
        if (cur[k] % w != 0) ex_err[k] = 1'b1; else pend[k] = 1'b1;
      end
    ok = 1'b1; lead = 0;
    for (int k = T - 1; k >= 0; k--) if (pend[k]) lead = k;
    base = cur[lead] - lead * w;
    for (int k = 0; k < T; k++) if (pend[k] && cur[k] != base + k * w) ok = 1'b0;
    span = (16 * w > 128) ? 128 : 16 * int'(w);
    if (base % span != 0) ok = 1'b0;
    while (pend != 0) begin
      for (int k = T - 1; k >= 0; k--) if (pend[k]) lead = k;
      if (!v.rel) begin
        if (!ok) begin
          m = 16'd1 << lead;
          seg = cur[lead] & ~32'd31; len = 32;
        end else begin
          len = span; seg = cur[lead] / len * len; m = '0;
          for (int k = 0; k < T; k++) if (pend[k] && cur[k] / len * len == seg) m[k] = 1'b1;
        end
      end else begin
        len = (v.sz == 0) ? 32 : (v.sz == 1) ? 64 : 128;
        seg = cur[lead] / len * len; m = '0;
        for (int k = 0; k < T; k++) if (pend[k] && cur[k] / len * len == seg) m[k] = 1'b1;
        while (len > 32) begin
          h = len / 2; lo = 1'b1; hi = 1'b1;
          for (int k = 0; k < T; k++)
            if (m[k]) begin
              if (cur[k] >= seg + h) lo = 1'b0; else hi = 1'b0;
            end
          if (lo) len = h;
          else if (hi) begin seg = seg + h; len = h; end
          else break;
        end
      end
      push(seg, len, m);
      pend = pend & ~m;
    end
  endtask

  task automatic run_vec(input vec_t v, input bit stall, input int idx);
    int n, cyc;
    string tg;
    logic [31:0] h_addr;
    logic [15:0] h_mask;
    logic [7:0]  h_len;
    tg = tag_of(v);
    mk_addr(v);
    model(v);
    @(negedge clk);
    in_valid = 1'b1; in_relaxed = v.rel; in_size = v.sz; in_active = v.act;
    for (int k = 0; k < T; k++) in_addr[k*32 +: 32] = cur[k];
    out_ready = !stall;
    @(negedge clk);
    in_valid = 1'b0;
    chk(err_mask == ex_err, "R2", $sformatf("error mask vec %0d", idx), 32'(err_mask), 32'(ex_err));
    chk(in_ready == (ex_n == 0), "R1", $sformatf("in_ready after accept vec %0d", idx), 32'(in_ready), 32'(ex_n == 0));
    if (stall && out_valid) begin
      h_addr = out_addr; h_mask = out_mask; h_len = out_len;
      for (int s = 0; s < 3; s++) begin
        @(negedge clk);
        chk(out_valid && out_addr == h_addr && out_mask == h_mask && out_len == h_len,
            "R9", "held transaction", out_addr, h_addr);
      end
      out_ready = 1'b1;
    end
    n = 0; cyc = 0;
    while (!in_ready && cyc < 80) begin
      if (out_valid && out_ready) begin
        if (n < ex_n) begin
          chk(out_addr == ex_addr[n], tg, $sformatf("addr vec %0d tx %0d", idx, n), out_addr, ex_addr[n]);
          chk(out_len == ex_len[n], tg, $sformatf("len vec %0d tx %0d", idx, n), 32'(out_len), 32'(ex_len[n]));
          chk(out_mask == ex_mask[n], "R8", $sformatf("mask vec %0d tx %0d", idx, n), 32'(out_mask), 32'(ex_mask[n]));
        end else chk(1'b0, tg, "extra transaction", n, ex_n);
        n++;
      end
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 80, "R1", "instruction drained", cyc, 80);
    chk(n == ex_n && n == int'(v.cnt), tg, $sformatf("transaction count vec %0d", idx), n, 32'(v.cnt));
    if (ex_n == 0) chk(!out_valid && in_ready, "R1", "empty instruction idle", 32'(out_valid), 0);
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid && err_mask == '0, "R1", "reset state", {in_ready, out_valid}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R1", "idle after reset", {in_ready, out_valid}, 32'h2);
    for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0, i);
    run_vec(VEC[15], 1'b1, 15);
    run_vec(VEC[4], 1'b1, 4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule